// File: doc/BRIEF.md
# Shift-Immediate Decode and Execute Unit

This unit accepts one 32-bit instruction word together with a 64-bit source operand and, one clock later, presents the outcome of the immediate-count shift that the word encodes. Two opcode groups are handled.

The full-width group shifts the whole 64-bit operand left, right logically or right arithmetically. The half-width group shifts only the low 32 bits and then sign-extends the 32-bit outcome to 64 bits. The shift count is always an unsigned field taken straight from the instruction, never the sign-extended immediate.

For comparison and for use by neighbouring arithmetic logic, the unit also registers the ordinary 12-bit sign-extended immediate from bits [31:20] for every accepted word. It drives two flags. One says the word was recognised as a shift. The other says the word was recognised as a shift but its upper bits hold a reserved pattern.

Top module: `shimm_unit`

## Requirements
- R1: `out_valid` is high exactly one clock after a clock edge at which `in_valid` was high, and low one clock after `in_valid` was low. A synchronous active-high `rst` clears `out_valid`, `is_shift` and `illegal`, even if `in_valid` is high during reset.
- R2: Opcode 7'b0010011 with funct3 (bits [14:12]) = 3'b001 and bits [31:26] = 6'b000000 yields the operand shifted left by bits [25:20].
- R3: Opcode 7'b0010011 with funct3 = 3'b101 yields a 64-bit right shift by bits [25:20]. Bits [31:26] = 6'b000000 gives a logical shift. Bits [31:26] = 6'b010000 (bit 30 set) gives an arithmetic shift.
- R4: The full-width shift count is the unsigned 6-bit value of bits [25:20], so counts 32 to 63 shift by that amount.
- R5: Opcode 7'b0011011 with funct3 = 3'b001 and bits [31:25] = 7'b0000000 shifts bits [31:0] of the operand left by bits [24:20] and sign-extends the 32-bit outcome.
- R6: Opcode 7'b0011011 with funct3 = 3'b101 and bits [31:25] = 7'b0000000 shifts bits [31:0] right as an unsigned value by bits [24:20] and sign-extends the 32-bit outcome.
- R7: Opcode 7'b0011011 with funct3 = 3'b101 and bits [31:25] = 7'b0100000 shifts bits [31:0] right as a signed value by bits [24:20] and sign-extends the 32-bit outcome.
- R8: A recognised shift with reserved upper bits raises both `is_shift` and `illegal` and drives `result` to zero. For the full-width left shift, only bits [31:26] = 000000 is allowed. For the full-width right shifts, only 000000 and 010000 are allowed. For the half-width left shift, only bits [31:25] = 0000000 is allowed. For the half-width right shifts, only 0000000 and 0100000 are allowed, so bit 25 set is always reserved in the half-width group.
- R9: Any other opcode or funct3 gives `is_shift` = 0, `illegal` = 0 and `result` = 0.
- R10: `imm_out` is bits [31:20] of the accepted word, sign-extended to 64 bits, for shift and non-shift words alike.
- R11: While `out_valid` is low, `is_shift` and `illegal` are low, and `result` and `imm_out` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operand are valid this cycle |
| instr | input | 32 | Instruction word |
| src | input | 64 | Source operand |
| out_valid | output | 1 | Registered outputs carry a new result |
| result | output | 64 | Shift outcome, zero for non-shift or reserved encodings |
| is_shift | output | 1 | Word was recognised as a shift-immediate |
| illegal | output | 1 | Recognised shift with reserved upper bits |
| imm_out | output | 64 | Sign-extended 12-bit immediate of the word |

## Verification
The shift outcome and the exported immediate are produced from the same word in the same cycle, and their bit fields overlap. A right-arithmetic encoding yields a positive immediate of 0x400 plus the count, while the shift itself must use only the 6-bit count. Reserved encodings with bit 31 set yield a negative immediate while `result` must be zero. The scoreboard compares both outputs for every accepted word, including back-to-back words and idle gaps where both outputs must hold.

// File: rtl/shimm_pkg.sv
package shimm_pkg;
  localparam logic [6:0] OPC_IMM_FULL = 7'b0010011;
  localparam logic [6:0] OPC_IMM_HALF = 7'b0011011;
  localparam logic [2:0] F3_LEFT      = 3'b001;
  localparam logic [2:0] F3_RIGHT     = 3'b101;
  localparam int         IMM_W        = 12;

  typedef enum logic [1:0] {
    SH_LEFT = 2'd0,
    SH_RLOG = 2'd1,
    SH_RARI = 2'd2
  } sh_kind_e;

  typedef struct packed {
    logic     hit;
    logic     bad;
    logic     half;
    sh_kind_e kind;
  } sh_ctrl_t;
endpackage

// File: rtl/shimm_decode.sv
module shimm_decode
  import shimm_pkg::*;
(
  input  logic [31:0] instr,
  output sh_ctrl_t    ctrl
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic       grp_full;
  logic       grp_half;

  assign opc      = instr[6:0];
  assign f3       = instr[14:12];
  assign grp_full = (opc == OPC_IMM_FULL);
  assign grp_half = (opc == OPC_IMM_HALF);

  always_comb begin
    ctrl      = '0;
    ctrl.kind = SH_LEFT;
    if ((grp_full || grp_half) && (f3 == F3_LEFT || f3 == F3_RIGHT)) begin
      ctrl.hit  = 1'b1;
      ctrl.half = grp_half;
      if (f3 == F3_LEFT)   ctrl.kind = SH_LEFT;
      else if (instr[30])  ctrl.kind = SH_RARI;
      else                 ctrl.kind = SH_RLOG;
      if (grp_full) begin
        if (f3 == F3_LEFT) ctrl.bad = (instr[31:26] != 6'b000000);
        else               ctrl.bad = (instr[31:26] != 6'b000000) &&
                                      (instr[31:26] != 6'b010000);
      end else begin
        if (f3 == F3_LEFT) ctrl.bad = (instr[31:25] != 7'b0000000);
        else               ctrl.bad = (instr[31:25] != 7'b0000000) &&
                                      (instr[31:25] != 7'b0100000);
      end
    end
  end

  // R8: a reserved pattern is only ever flagged on a recognised shift
  always_comb begin
    p_bad_needs_hit_r8: assert (!(ctrl.bad && !ctrl.hit));
  end
endmodule

// File: rtl/shimm_exec.sv
module shimm_exec
  import shimm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         src,
  input  logic [$clog2(XLEN)-1:0] amt,
  input  logic                    half,
  input  sh_kind_e                kind,
  output logic [XLEN-1:0]         res
);
  localparam int HALF = XLEN / 2;
  localparam int HSHW = $clog2(HALF);

  logic [HALF-1:0] lo;
  logic [HALF-1:0] lo_res;
  logic [XLEN-1:0] full_res;
  logic [HSHW-1:0] amt_lo;

  assign lo     = src[HALF-1:0];
  assign amt_lo = amt[HSHW-1:0];

  always_comb begin
    case (kind)
      SH_LEFT: begin
        full_res = src << amt;
        lo_res   = lo << amt_lo;
      end
      SH_RLOG: begin
        full_res = src >> amt;
        lo_res   = lo >> amt_lo;
      end
      SH_RARI: begin
        full_res = XLEN'($signed(src) >>> amt);
        lo_res   = HALF'($signed(lo) >>> amt_lo);
      end
      default: begin
        full_res = '0;
        lo_res   = '0;
      end
    endcase
    res = half ? {{HALF{lo_res[HALF-1]}}, lo_res} : full_res;
  end

  // R3: a nonzero full-width logical right shift always clears the top bit
  always_comb begin
    if (!half && kind == SH_RLOG && amt != '0)
      p_rlog_top_clear_r3: assert (res[XLEN-1] == 1'b0);
  end
endmodule

// File: rtl/shimm_unit.sv
module shimm_unit
  import shimm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] src,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            is_shift,
  output logic            illegal,
  output logic [XLEN-1:0] imm_out
);
  localparam int SHW = $clog2(XLEN);

  sh_ctrl_t        ctrl;
  logic [XLEN-1:0] sh_res;
  logic [XLEN-1:0] imm_sext;

  shimm_decode u_dec (
    .instr (instr),
    .ctrl  (ctrl)
  );

  shimm_exec #(.XLEN(XLEN)) u_exec (
    .src  (src),
    .amt  (instr[20 +: SHW]),
    .half (ctrl.half),
    .kind (ctrl.kind),
    .res  (sh_res)
  );

  assign imm_sext = {{(XLEN-IMM_W){instr[31]}}, instr[31:20]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      is_shift  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      is_shift  <= in_valid && ctrl.hit;
      illegal   <= in_valid && ctrl.bad;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      result  <= (ctrl.hit && !ctrl.bad) ? sh_res : '0;
      imm_out <= imm_sext;
    end
  end

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_fall_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_flags_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!is_shift && !illegal));
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(imm_out)));
  p_illegal_is_shift_r8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> is_shift);
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (result == '0));
  p_nonshift_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !is_shift) |-> (result == '0));
endmodule

// File: tb/shimm_unit_test.sv
`timescale 1ns/1ps
module shimm_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        is_shift;
  logic        illegal;
  logic [63:0] imm_out;

  always #2.5 clk = ~clk;

  shimm_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .src(src),
    .out_valid(out_valid), .result(result), .is_shift(is_shift),
    .illegal(illegal), .imm_out(imm_out)
  );

  typedef struct {
    logic [63:0] res;
    logic [63:0] imm;
    logic        sh;
    logic        bad;
    int          cyc;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  logic [63:0] last_res, last_imm;
  bit   have_last = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [31:0] w, input logic [63:0] a);
    exp_t e;
    logic [31:0] h;
    logic [5:0]  c6 = w[25:20];
    logic [4:0]  c5 = w[24:20];
    e.imm = {{52{w[31]}}, w[31:20]};
    e.sh = 0; e.bad = 0; e.res = '0; e.cyc = 0; e.req = "";
    if (w[6:0] == 7'b0010011 && w[14:12] == 3'd1) begin
      e.sh = 1;
      if (w[31:26] == 6'd0) e.res = a << c6; else e.bad = 1;
    end else if (w[6:0] == 7'b0010011 && w[14:12] == 3'd5) begin
      e.sh = 1;
      if (w[31:26] == 6'b000000)      e.res = a >> c6;
      else if (w[31:26] == 6'b010000) e.res = 64'($signed(a) >>> c6);
      else                            e.bad = 1;
    end else if (w[6:0] == 7'b0011011 && w[14:12] == 3'd1) begin
      e.sh = 1;
      if (w[31:25] == 7'd0) begin h = a[31:0] << c5; e.res = {{32{h[31]}}, h}; end
      else e.bad = 1;
    end else if (w[6:0] == 7'b0011011 && w[14:12] == 3'd5) begin
      e.sh = 1;
      if (w[31:25] == 7'b0000000) begin
        h = a[31:0] >> c5; e.res = {{32{h[31]}}, h};
      end else if (w[31:25] == 7'b0100000) begin
        h = 32'($signed(a[31:0]) >>> c5); e.res = {{32{h[31]}}, h};
      end else e.bad = 1;
    end
    return e;
  endfunction

  function automatic logic [31:0] enc(input logic [6:0] top7, input logic [4:0] c5,
                                      input logic [2:0] f3, input logic [6:0] opc);
    return {top7, c5, 5'd3, f3, 5'd7, opc};
  endfunction

  task automatic send(input logic [31:0] w, input logic [63:0] a, input string req);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; instr = w; src = a;
    e = model(w, a);
    e.cyc = cyc; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      instr = 32'hFFFF_FFFF; src = 64'hDEAD_BEEF_0BAD_F00D;
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (!rst) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          chk(0, "R1", "out_valid without input", 64'd1, 64'd0);
        end else begin
          e = q.pop_front();
          chk(cyc == e.cyc + 1, "R1", "latency", 64'(cyc), 64'(e.cyc + 1));
          chk(result == e.res, e.req, "result", result, e.res);
          chk(is_shift == e.sh, e.req, "is_shift", 64'(is_shift), 64'(e.sh));
          chk(illegal == e.bad, e.req, "illegal", 64'(illegal), 64'(e.bad));
          chk(imm_out == e.imm, "R10", "imm_out", imm_out, e.imm);
          last_res = result; last_imm = imm_out; have_last = 1;
        end
      end else begin
        chk(!is_shift && !illegal, "R11", "flags while idle",
            64'({is_shift, illegal}), 64'd0);
        if (have_last) begin
          chk(result == last_res, "R11", "result hold", result, last_res);
          chk(imm_out == last_imm, "R11", "imm hold", imm_out, last_imm);
        end
      end
    end
  end

  localparam logic [6:0] OF = 7'b0010011;
  localparam logic [6:0] OH = 7'b0011011;
  localparam logic [63:0] A = 64'hF0E1_D2C3_84A5_9687;
  localparam logic [63:0] B = 64'h0123_4567_7654_3210;

  initial begin
    repeat (2) @(negedge clk);
    in_valid = 1'b1; instr = enc(7'd0, 5'd1, 3'd1, OF);
    @(negedge clk);
    chk(out_valid == 0 && is_shift == 0 && illegal == 0, "R1", "reset state",
        64'({out_valid, is_shift, illegal}), 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;

    send(enc(7'd0, 5'd0, 3'd1, OF), A, "R2");
    send(enc(7'd0, 5'd4, 3'd1, OF), B, "R2");
    send(enc(7'b0000001, 5'd31, 3'd1, OF), A, "R4");
    idle(2);
    send(enc(7'b0000001, 5'd8, 3'd5, OF), A, "R4");
    send(enc(7'b0000000, 5'd12, 3'd5, OF), A, "R3");
    send(enc(7'b0100000, 5'd12, 3'd5, OF), A, "R3");
    send(enc(7'b0100001, 5'd31, 3'd5, OF), A, "R3");
    send(enc(7'b0100001, 5'd1, 3'd5, OF), B, "R4");
    idle(1);
    send(enc(7'd0, 5'd31, 3'd1, OH), 64'h1, "R5");
    send(enc(7'd0, 5'd4, 3'd1, OH), B, "R5");
    send(enc(7'd0, 5'd0, 3'd5, OH), 64'h0000_0000_8000_0000, "R6");
    send(enc(7'd0, 5'd8, 3'd5, OH), A, "R6");
    send(enc(7'b0100000, 5'd31, 3'd5, OH), A, "R7");
    send(enc(7'b0100000, 5'd4, 3'd5, OH), A, "R7");
    send(enc(7'b0100000, 5'd4, 3'd5, OH), B, "R7");
    idle(3);
    send(enc(7'b0100000, 5'd3, 3'd1, OF), A, "R8");
    send(enc(7'b1000000, 5'd3, 3'd5, OF), A, "R8");
    send(enc(7'b0000001, 5'd3, 3'd1, OH), A, "R8");
    send(enc(7'b0100001, 5'd3, 3'd5, OH), A, "R8");
    send(enc(7'b0100000, 5'd3, 3'd1, OH), A, "R8");
    send(enc(7'b1111111, 5'd31, 3'd5, OF), A, "R8");
    idle(1);
    send(enc(7'b1000000, 5'd5, 3'd0, OF), A, "R9");
    send(enc(7'b0000000, 5'd5, 3'd1, 7'b0110011), A, "R9");
    send(enc(7'b0100000, 5'd5, 3'd5, 7'b0110011), A, "R9");
    send(enc(7'b0111111, 5'd31, 3'd6, OF), A, "R10");
    idle(4);
    chk(q.size() == 0, "R1", "scoreboard drained", 64'(q.size()), 64'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule